// File: doc/BRIEF.md
# Burst Cycle Control Sequencer

This block is the control front end of a synchronous SRAM port that runs reads and writes back to back with no idle cycle between them. On each rising clock edge it takes the registered control pins, decides which operation the current cycle carries, and produces the word address for the storage array. It also produces a per-byte write mask and a flag that tells the data pad logic whether to drive the shared bus. The array itself and the pad timing sit outside it.

An operation is chosen only on an edge where the load strobe is low. That edge also captures the chip selects, the read/write pin and the address. Later edges with the strobe high continue a four-beat burst of the same kind. A 2-bit counter then replaces the two low address bits, in linear or interleaved order. A clock-enable pin can stall any edge. A snooze pin overrides everything and holds the port deselected with its bus released.

Top module: `bcs_seq`

## Requirements
- R1: A synchronous reset, active high, gives a deselected cycle with `burst_cnt` = 0, `byte_mask` = 0 and `bus_drive` low. Cycle codes on `cyc_type` are: 0 deselect, 1 read, 2 write, 3 write abort, 4 dummy read.
- R2: On an enabled edge with `adv_ld_n` low, the port is selected only when `ce1_n`=0, `ce2_n`=0 and `ce3`=1. A selected load starts a read when `rw_n`=1 and a write when `rw_n`=0. Any other enable combination gives a deselect cycle.
- R3: On an enabled edge with `adv_ld_n` high, `rw_n` and the chip selects have no effect, and the operation chosen at the last load continues.
- R4: Each continue edge of a read or write burst adds one, modulo 4, to `burst_cnt`, so the fifth beat returns to the start address. A load clears the counter to 0. The address bits above bit 1 stay at their loaded value for the whole burst.
- R5: With `mode_ilv`=0, the low two bits of `word_addr` are (start low bits + `burst_cnt`) mod 4.
- R6: With `mode_ilv`=1, the low two bits of `word_addr` are start low bits XOR `burst_cnt`.
- R7: An edge with `cke_n` high changes no state: the operation, address, counter and mask all keep their values.
- R8: `byte_mask` bit i is high when `bw_n` bit i was low on the last enabled edge of a write cycle, and is 0 for any other cycle. A write whose mask is all zero reports the abort code 3.
- R9: A read cycle reports code 1 and raises `bus_drive` while `oe_n` is low. It reports dummy-read code 4, with `bus_drive` low, while `oe_n` is high. `bus_drive` is high only for code 1.
- R10: While `snooze` is high, the outputs show a deselect cycle with a zero mask and `bus_drive` low, and no other input has any effect. An edge during snooze leaves the sequencer deselected.
- R11: After a deselect, edges with `adv_ld_n` high keep the port deselected and leave `burst_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; high stalls the edge |
| ce1_n | input | 1 | First chip select, active low |
| ce2_n | input | 1 | Second chip select, active low |
| ce3 | input | 1 | Third chip select, active high |
| adv_ld_n | input | 1 | Low loads a new address and operation; high continues |
| rw_n | input | 1 | High read, low write; used only at load |
| bw_n | input | 4 | Byte write enables, active low, bit i for byte i |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| mode_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| snooze | input | 1 | Low-power override, active high |
| addr_in | input | AW | External word address |
| word_addr | output | AW | Array word address for the current cycle |
| burst_cnt | output | 2 | Beat counter within the burst |
| cyc_type | output | 3 | Operation of the current cycle |
| byte_mask | output | 4 | Active-high byte write mask |
| bus_drive | output | 1 | High when the data bus is to be driven |

## Verification
A wrong stored operation shows on `cyc_type` in the very cycle after the edge that caused it. A burst that switched from write to read, or one that left deselect without a load, is therefore visible one clock later. A wrong counter or start offset shows on the low bits of `word_addr` at once. A bad wrap only shows on the fifth beat, so bursts are driven past four beats in both orders. A stall that leaks into state shows as a change in address, mask or code across a held edge. The bench's reference model compares every output after every clock.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_RD    = 3'd1,
    CYC_WR    = 3'd2,
    CYC_ABORT = 3'd3,
    CYC_DUMMY = 3'd4
  } cyc_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  localparam int unsigned BYTES = 4;

  // Low address bits for a beat: XOR order or modulo-4 increment.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       ilv);
    return ilv ? (start ^ cnt) : (start + cnt);
  endfunction

  // Port is selected only for the single valid enable combination.
  function automatic logic chip_selected(input logic e1_n,
                                         input logic e2_n,
                                         input logic e3);
    return !e1_n && !e2_n && e3;
  endfunction

endpackage

// File: rtl/bcs_burst_addr.sv
module bcs_burst_addr
  import bcs_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_ev,
  input  logic          cont_ev,
  input  logic          ilv,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] word_addr,
  output logic [1:0]    cnt
);
  localparam int unsigned UW = AW - 2;

  logic [UW-1:0] upper_q;
  logic [1:0]    start_q;
  logic [1:0]    cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (load_ev) begin
      upper_q <= addr_in[AW-1:2];
      start_q <= addr_in[1:0];
      cnt_q   <= '0;
    end else if (cont_ev) begin
      cnt_q   <= cnt_q + 2'd1;
    end
  end

  assign word_addr = {upper_q, beat_low(start_q, cnt_q, ilv)};
  assign cnt       = cnt_q;

  p_upper_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    cont_ev |=> $stable(upper_q) && $stable(start_q));

  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    cont_ev |=> cnt_q == $past(cnt_q) + 2'd1);

  p_load_clears_r4: assert property (@(posedge clk) disable iff (rst)
    load_ev |=> cnt_q == 2'd0);

endmodule

// File: rtl/bcs_cycle_ctl.sv
module bcs_cycle_ctl
  import bcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       snooze,
  input  logic       cke_n,
  input  logic       adv_ld_n,
  input  logic       sel,
  input  logic       rw_n,
  input  logic [3:0] bw_n,
  output op_e        op,
  output logic [3:0] mask,
  output logic       load_ev,
  output logic       cont_ev
);
  op_e        op_q;
  logic [3:0] mask_q;
  logic       edge_en;

  assign edge_en = !cke_n && !snooze;
  assign load_ev = edge_en && !adv_ld_n;
  assign cont_ev = edge_en && adv_ld_n && (op_q != OP_NONE);

  always_ff @(posedge clk) begin
    if (rst || snooze) begin
      op_q   <= OP_NONE;
      mask_q <= '0;
    end else if (load_ev) begin
      if (!sel)       op_q <= OP_NONE;
      else if (rw_n)  op_q <= OP_RD;
      else            op_q <= OP_WR;
      mask_q <= (sel && !rw_n) ? ~bw_n : 4'b0000;
    end else if (edge_en) begin
      mask_q <= (op_q == OP_WR) ? ~bw_n : 4'b0000;
    end
  end

  assign op   = op_q;
  assign mask = mask_q;

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (cke_n && !snooze) |=> $stable(op_q) && $stable(mask_q));

  p_rw_ignored_r3: assert property (@(posedge clk) disable iff (rst)
    (edge_en && adv_ld_n) |=> op_q == $past(op_q));

  p_desel_load_r2: assert property (@(posedge clk) disable iff (rst)
    (load_ev && !sel) |=> op_q == OP_NONE);

  p_snooze_idle_r10: assert property (@(posedge clk) disable iff (rst)
    snooze |=> op_q == OP_NONE && mask_q == 4'b0000);

  p_stay_desel_r11: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_NONE && adv_ld_n) |=> op_q == OP_NONE);

endmodule

// File: rtl/bcs_seq.sv
module bcs_seq
  import bcs_pkg::*;
#(
  parameter int unsigned AW = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cke_n,
  input  logic          ce1_n,
  input  logic          ce2_n,
  input  logic          ce3,
  input  logic          adv_ld_n,
  input  logic          rw_n,
  input  logic [3:0]    bw_n,
  input  logic          oe_n,
  input  logic          mode_ilv,
  input  logic          snooze,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] word_addr,
  output logic [1:0]    burst_cnt,
  output logic [2:0]    cyc_type,
  output logic [3:0]    byte_mask,
  output logic          bus_drive
);
  op_e        op;
  logic [3:0] mask;
  logic       load_ev;
  logic       cont_ev;
  logic       sel;
  cyc_e       cyc;

  assign sel = chip_selected(ce1_n, ce2_n, ce3);

  bcs_cycle_ctl u_ctl (
    .clk      (clk),
    .rst      (rst),
    .snooze   (snooze),
    .cke_n    (cke_n),
    .adv_ld_n (adv_ld_n),
    .sel      (sel),
    .rw_n     (rw_n),
    .bw_n     (bw_n),
    .op       (op),
    .mask     (mask),
    .load_ev  (load_ev),
    .cont_ev  (cont_ev)
  );

  bcs_burst_addr #(.AW(AW)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load_ev   (load_ev),
    .cont_ev   (cont_ev),
    .ilv       (mode_ilv),
    .addr_in   (addr_in),
    .word_addr (word_addr),
    .cnt       (burst_cnt)
  );

  always_comb begin
    cyc = CYC_IDLE;
    if (!snooze) begin
      case (op)
        OP_RD:   cyc = oe_n ? CYC_DUMMY : CYC_RD;
        OP_WR:   cyc = (mask == 4'b0000) ? CYC_ABORT : CYC_WR;
        default: cyc = CYC_IDLE;
      endcase
    end
  end

  assign cyc_type  = cyc;
  assign byte_mask = snooze ? 4'b0000 : mask;
  assign bus_drive = (cyc == CYC_RD);

  p_bus_gate_r9: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (!oe_n && !snooze && op == OP_RD));

  p_stall_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (cke_n && !snooze) |=> $stable(burst_cnt));

  p_snooze_out_r10: assert property (@(posedge clk) disable iff (rst)
    snooze |-> (cyc_type == 3'd0 && !bus_drive && byte_mask == 4'b0000));

endmodule

// File: tb/bcs_seq_tb_top.sv
`timescale 1ns/1ps
module bcs_seq_tb_top;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst, cke_n, ce1_n, ce2_n, ce3, adv_ld_n, rw_n, oe_n, mode_ilv, snooze;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] word_addr;
  logic [1:0]    burst_cnt;
  logic [2:0]    cyc_type;
  logic [3:0]    byte_mask;
  logic          bus_drive;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state: op 0 none, 1 read, 2 write
  int m_op = 0, m_mask = 0, m_cnt = 0, m_start = 0, m_upper = 0;

  always #2.5 clk = ~clk;

  bcs_seq #(.AW(AW)) dut_i (
    .clk(clk), .rst(rst), .cke_n(cke_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3),
    .adv_ld_n(adv_ld_n), .rw_n(rw_n), .bw_n(bw_n), .oe_n(oe_n), .mode_ilv(mode_ilv),
    .snooze(snooze), .addr_in(addr_in), .word_addr(word_addr), .burst_cnt(burst_cnt),
    .cyc_type(cyc_type), .byte_mask(byte_mask), .bus_drive(bus_drive)
  );

  task automatic model_edge();
    if (rst) begin
      m_op = 0; m_mask = 0; m_cnt = 0; m_start = 0; m_upper = 0;
    end else if (snooze) begin
      m_op = 0; m_mask = 0;
    end else if (!cke_n) begin
      if (!adv_ld_n) begin
        if (ce1_n || ce2_n || !ce3) m_op = 0;
        else m_op = rw_n ? 1 : 2;
        m_mask  = (m_op == 2) ? (15 - int'(bw_n)) : 0;
        m_upper = int'(addr_in) / 4;
        m_start = int'(addr_in) % 4;
        m_cnt   = 0;
      end else begin
        if (m_op != 0) m_cnt = (m_cnt + 1) % 4;
        m_mask = (m_op == 2) ? (15 - int'(bw_n)) : 0;
      end
    end
  endtask

  task automatic compare(input string tag);
    int lo, e_addr, e_cyc, e_mask, e_bus;
    lo     = mode_ilv ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
    e_addr = m_upper * 4 + lo;
    if (snooze)            e_cyc = 0;
    else if (m_op == 1)    e_cyc = oe_n ? 4 : 1;
    else if (m_op == 2)    e_cyc = (m_mask == 0) ? 3 : 2;
    else                   e_cyc = 0;
    e_mask = snooze ? 0 : m_mask;
    e_bus  = (e_cyc == 1) ? 1 : 0;
    n_chk++;
    if (int'(word_addr) != e_addr || int'(burst_cnt) != m_cnt || int'(cyc_type) != e_cyc ||
        int'(byte_mask) != e_mask || int'(bus_drive) != e_bus) begin
      n_bad++;
      $display("FAIL %s: addr=%0h cnt=%0d cyc=%0d mask=%0h bus=%0d expected addr=%0h cnt=%0d cyc=%0d mask=%0h bus=%0d",
               tag, word_addr, burst_cnt, cyc_type, byte_mask, bus_drive,
               e_addr, m_cnt, e_cyc, e_mask, e_bus);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    #1;
    compare(tag);
  endtask

  task automatic ld(input bit rd, input int a, input logic [3:0] bw);
    adv_ld_n = 1'b0; rw_n = rd; addr_in = AW'(a); bw_n = bw;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; cke_n = 0; ce1_n = 0; ce2_n = 0; ce3 = 1; adv_ld_n = 1; rw_n = 1;
    bw_n = 4'hF; oe_n = 0; mode_ilv = 0; snooze = 0; addr_in = '0;
    step("R1 reset"); step("R1 reset");
    rst = 0;
    step("R11 idle after reset");

    // linear write burst, R2 R8 R5; rw_n flipped during continue R3
    mode_ilv = 0;
    ld(0, 8'h25, 4'b0101); step("R2 load write");
    adv_ld_n = 1; rw_n = 1; bw_n = 4'b0000;
    for (int i = 0; i < 5; i++) step("R5 R4 R3 linear write burst wrap");
    bw_n = 4'b1111; step("R8 burst beat abort mask");

    // interleaved read burst R6
    mode_ilv = 1; oe_n = 0;
    ld(1, 8'h4E, 4'b0000); step("R2 load read");
    adv_ld_n = 1; rw_n = 0;
    for (int i = 0; i < 5; i++) step("R6 R3 interleaved read burst");
    oe_n = 1; step("R9 dummy read");
    oe_n = 0;

    // stall R7: inputs that would otherwise act
    cke_n = 1; adv_ld_n = 0; rw_n = 0; addr_in = 8'hF3; bw_n = 4'b0000;
    step("R7 stall"); step("R7 stall");
    cke_n = 0; adv_ld_n = 1; step("R7 resume continue");

    // write abort at load R8
    ld(0, 8'h10, 4'b1111); step("R8 abort load");
    ld(0, 8'h11, 4'b1110); step("R8 single byte");
    ld(0, 8'h12, 4'b0111); step("R8 top byte");

    // deselect combinations R2, then continue deselect R11
    ce1_n = 1; ld(1, 8'h33, 4'hF); step("R2 ce1 deselect");
    ce1_n = 0; ce2_n = 1; step("R2 ce2 deselect");
    ce2_n = 0; ce3 = 0; step("R2 ce3 deselect");
    ce3 = 1; adv_ld_n = 1; rw_n = 0;
    step("R11 continue deselect"); step("R11 continue deselect");

    // snooze R10
    mode_ilv = 0;
    ld(1, 8'h61, 4'hF); step("R2 read before snooze");
    snooze = 1; adv_ld_n = 0; rw_n = 0; bw_n = 4'h0;
    step("R10 snooze"); step("R10 snooze");
    snooze = 0; adv_ld_n = 1; step("R10 after snooze stays deselected");
    ld(0, 8'hFF, 4'b0000); step("R5 write at top address");
    adv_ld_n = 1; step("R5 linear wrap of low bits");

    rst = 1; step("R1 reset mid run");
    rst = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule